// File: doc/BRIEF.md
# Pipelined Tiled Deep Memory

A single-port synchronous word memory whose storage is split across a grid of identical tiles: four columns of four tiles each. The top bits of the address choose a column, the next bits choose a tile inside that column, and the low bits pick the word inside the tile. In each column the tile outputs run through a vertical cascade chain. A horizontal cascade chain then merges the four column results into one read word.

Every enabled access is also a read. Two registers form the core access: the tile output register and the merged output register. The `LATENCY` parameter sets the total read latency. `LATENCY - 2` further register stages follow the core access on the read path. Each data stage has its own enable stage beside it, and a data stage loads only when its incoming enable is high. The last enable stage drives `rd_valid`. A `LATENCY` below 2 stops elaboration with an error.

The default tile holds 256 words, so a default build stays small. Setting `TILE_AW = 12` gives the full 64K x 72 configuration. With a 4x4 grid, eight extra stages pipeline the grid completely. More stages than that only add flip-flops.

Top module: `tiled_deep_mem`

## Requirements
- R1: The word address is `{col[1:0], row[1:0], index[TILE_AW-1:0]}`, with the column in the top two bits. Each of the 16 tiles keeps its own 72-bit words, and a read returns the word last written to exactly that address.
- R2: A word is written only in a cycle where `mem_en` and `wr_en` are both high. A cycle with `wr_en` high and `mem_en` low changes no stored word.
- R3: An access with `mem_en` and `wr_en` high returns, as its read data, the word held at that address before the write (read-first). A later read returns the new word.
- R4: `rd_valid` is high in exactly the cycle `LATENCY` cycles after the cycle in which an access was presented. `rd_data` holds that access's word in the same cycle. This holds for LATENCY = 2, 4 and 10.
- R5: Accesses presented on consecutive cycles produce `rd_valid` on consecutive cycles, in request order, with no gaps.
- R6: While `rd_valid` is low, `rd_data` keeps the value of the most recent valid read.
- R7: While `rst_n` is low, and in the first cycle after it rises, `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the enable pipeline |
| mem_en | input | 1 | Access request, sampled at the clock edge |
| wr_en | input | 1 | Write the addressed word when `mem_en` is high |
| addr | input | 4+TILE_AW | Word address: column, row, index |
| wr_data | input | 72 | Word to store |
| rd_data | output | 72 | Read word, held between valid reads |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a new read |

## Verification
The bench runs three copies of the block, at latencies 10, 4 and 2. Each copy is compared every cycle against a delayed behavioural record of requests, so an off-by-one latency shows up as `rd_valid` in the wrong cycle. Wrong column or row decoding shows up when reading back words placed in all 16 tiles. Write-data forwarding in place of read-first shows up on a write to a word, which would return the new word instead of the old one. The bench also checks three further faults: a write gated by `wr_en` alone, which would corrupt a word during a disabled cycle; data stages that load without their enable, which would let `rd_data` drift while `rd_valid` is low; and a stalling pipeline, which would put gaps into a burst of back-to-back reads.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Registers that form the basic access: tile output and merged output.
    localparam int unsigned CORE_REGS = 2;

    // Extra read-path stages that a given total latency leaves over.
    function automatic int unsigned extra_stages(input int unsigned lat);
        return (lat > CORE_REGS) ? lat - CORE_REGS : 0;
    endfunction

endpackage

// File: rtl/tdm_tile.sv
module tdm_tile #(
    parameter int unsigned DATA_W  = 72,
    parameter int unsigned TILE_AW = 8
) (
    input  logic               clk,
    input  logic               en,
    input  logic               we,
    input  logic [TILE_AW-1:0] idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd
);
    localparam int unsigned DEPTH = 1 << TILE_AW;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // Read-first: the output register takes the word before this edge's write.
    always_comb begin
        rd_d = rd_q;
        if (en) begin
            rd_d = store[idx];
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (en && we) begin
            store[idx] <= wdata;
        end
    end

    assign rd = rd_q;

endmodule

// File: rtl/tdm_column.sv
module tdm_column #(
    parameter int unsigned DATA_W   = 72,
    parameter int unsigned ROW_BITS = 2,
    parameter int unsigned TILE_AW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                col_en,
    input  logic                we,
    input  logic [ROW_BITS-1:0] row,
    input  logic [TILE_AW-1:0]  idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   casc_out
);
    localparam int unsigned ROWS = 1 << ROW_BITS;

    logic [ROWS-1:0]     tile_en;
    logic [DATA_W-1:0]   tile_out [ROWS];
    logic [DATA_W-1:0]   vchain   [ROWS];
    logic [ROW_BITS-1:0] row_d, row_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_tile
        assign tile_en[r] = col_en && (row == ROW_BITS'(r));

        tdm_tile #(
            .DATA_W (DATA_W),
            .TILE_AW(TILE_AW)
        ) u_tile (
            .clk  (clk),
            .en   (tile_en[r]),
            .we   (we),
            .idx  (idx),
            .wdata(wdata),
            .rd   (tile_out[r])
        );

        // Vertical cascade: each link either passes its own tile or the link below.
        if (r == 0) begin : g_base
            assign vchain[r] = tile_out[r];
        end else begin : g_link
            assign vchain[r] = (row_q == ROW_BITS'(r)) ? tile_out[r] : vchain[r-1];
        end
    end

    always_comb begin
        row_d = row_q;
        if (col_en) begin
            row_d = row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign casc_out = vchain[ROWS-1];

    AST_ONE_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tile_en)); // R1
    AST_IDLE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        !col_en |-> (tile_en == '0)); // R2

endmodule

// File: rtl/tdm_rdpipe.sv
module tdm_rdpipe #(
    parameter int unsigned DATA_W = 72,
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    if (STAGES == 0) begin : g_bypass
        assign out_vld  = in_vld;
        assign out_data = in_data;
    end else begin : g_stages
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] data;
        } stage_t;

        stage_t [STAGES-1:0] st_d, st_q;

        // Enable moves every cycle; data loads only behind a high enable.
        always_comb begin
            for (int i = 0; i < STAGES; i++) begin
                stage_t src;
                if (i == 0) begin
                    src.vld  = in_vld;
                    src.data = in_data;
                end else begin
                    src = st_q[i-1];
                end
                st_d[i].vld  = src.vld;
                st_d[i].data = src.vld ? src.data : st_q[i].data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_vld  = st_q[STAGES-1].vld;
        assign out_data = st_q[STAGES-1].data;
    end

endmodule

// File: rtl/tiled_deep_mem.sv
module tiled_deep_mem
    import tdm_pkg::*;
#(
    parameter int unsigned DATA_W   = 72,
    parameter int unsigned ROW_BITS = 2,
    parameter int unsigned COL_BITS = 2,
    parameter int unsigned TILE_AW  = 8,
    parameter int unsigned LATENCY  = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   mem_en,
    input  logic                                   wr_en,
    input  logic [COL_BITS+ROW_BITS+TILE_AW-1:0]   addr,
    input  logic [DATA_W-1:0]                      wr_data,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_valid
);
    localparam int unsigned COLS   = 1 << COL_BITS;
    localparam int unsigned ADDR_W = COL_BITS + ROW_BITS + TILE_AW;
    localparam int unsigned EXTRA  = extra_stages(LATENCY);
    localparam int unsigned PEND_W = $clog2(LATENCY + 2) + 1;

    if (LATENCY < CORE_REGS) begin : g_bad_latency
        $error("tiled_deep_mem: LATENCY must be at least 2");
    end

    // Address fields: column on top, then row, then the word index.
    logic [COL_BITS-1:0] col_sel;
    logic [ROW_BITS-1:0] row_sel;
    logic [TILE_AW-1:0]  word_idx;

    assign col_sel  = addr[ADDR_W-1 -: COL_BITS];
    assign row_sel  = addr[TILE_AW +: ROW_BITS];
    assign word_idx = addr[TILE_AW-1:0];

    typedef struct packed {
        logic                v1;
        logic [COL_BITS-1:0] col1;
        logic                v2;
        logic [DATA_W-1:0]   data2;
    } core_t;

    core_t core_d, core_q;

    logic [DATA_W-1:0] col_out [COLS];
    logic [DATA_W-1:0] hchain  [COLS];
    logic [DATA_W-1:0] merged;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic this_col;
        assign this_col = mem_en && (col_sel == COL_BITS'(c));

        tdm_column #(
            .DATA_W  (DATA_W),
            .ROW_BITS(ROW_BITS),
            .TILE_AW (TILE_AW)
        ) u_column (
            .clk     (clk),
            .rst_n   (rst_n),
            .col_en  (this_col),
            .we      (wr_en),
            .row     (row_sel),
            .idx     (word_idx),
            .wdata   (wr_data),
            .casc_out(col_out[c])
        );

        // Horizontal cascade across the columns.
        if (c == 0) begin : g_base
            assign hchain[c] = col_out[c];
        end else begin : g_link
            assign hchain[c] = (core_q.col1 == COL_BITS'(c)) ? col_out[c] : hchain[c-1];
        end
    end

    assign merged = hchain[COLS-1];

    always_comb begin
        core_d    = core_q;
        core_d.v1 = mem_en;
        if (mem_en) begin
            core_d.col1 = col_sel;
        end
        core_d.v2 = core_q.v1;
        if (core_q.v1) begin
            core_d.data2 = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    tdm_rdpipe #(
        .DATA_W(DATA_W),
        .STAGES(EXTRA)
    ) u_rdpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (core_q.v2),
        .in_data (core_q.data2),
        .out_vld (rd_valid),
        .out_data(rd_data)
    );

    // In-flight access counter used only by the checks below.
    logic [PEND_W-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q + PEND_W'(mem_en) - PEND_W'(rd_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_W'(LATENCY)); // R4
    AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (pend_q != '0)); // R4
    AST_STEADY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && pend_q == PEND_W'(LATENCY)) |=> rd_valid); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data)); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rd_valid); // R7

endmodule

// File: tb/tiled_deep_mem_test.sv
`timescale 1ns/1ps
module tiled_deep_mem_test;
    localparam int AW    = 12;
    localparam int DW    = 72;
    localparam int NWORD = 1 << AW;
    localparam int HMAX  = 8192;
    localparam int LAT [3] = '{10, 4, 2};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd [3];
    logic          rv [3];

    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string ph = "R7";

    logic [DW-1:0] model [NWORD];
    bit            known [NWORD];
    logic [DW-1:0] hist_d [HMAX];
    bit            hist_v [HMAX];
    bit            hist_w [HMAX];
    bit            hist_x [HMAX];
    logic [DW-1:0] last_d [3];
    bit            last_ok [3];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tiled_deep_mem #(.TILE_AW(8), .LATENCY(10)) uut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd[0]), .rd_valid(rv[0]));
    tiled_deep_mem #(.TILE_AW(8), .LATENCY(4)) uut_l4 (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd[1]), .rd_valid(rv[1]));
    tiled_deep_mem #(.TILE_AW(8), .LATENCY(2)) uut_l2 (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd[2]), .rd_valid(rv[2]));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare all three copies against the delayed request record.
    task automatic check_outputs();
        for (int k = 0; k < 3; k++) begin
            int    j  = cyc + 1 - LAT[k];
            bit    ev = (j >= 1) ? hist_v[j] : 1'b0;
            string vt = (ph == "R5" || ph == "R7") ? ph : "R4";
            chk(rv[k] == ev, vt, $sformatf("rd_valid L=%0d", LAT[k]),
                DW'(rv[k]), DW'(ev));
            if (ev) begin
                if (!hist_x[j]) begin
                    chk(rd[k] == hist_d[j], hist_w[j] ? "R3" : ph,
                        $sformatf("rd_data L=%0d", LAT[k]), rd[k], hist_d[j]);
                end
                last_ok[k] = !hist_x[j];
                last_d[k]  = hist_d[j];
            end else if (last_ok[k]) begin
                chk(rd[k] == last_d[k], "R6",
                    $sformatf("held rd_data L=%0d", LAT[k]), rd[k], last_d[k]);
            end
        end
    endtask

    task automatic step(input bit e, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        int n;
        @(negedge clk);
        if (chk_on) check_outputs();
        n = cyc + 1;
        mem_en  = e;
        wr_en   = w;
        addr    = a;
        wr_data = d;
        hist_v[n] = e;
        hist_w[n] = e && w;
        hist_x[n] = e && !known[a];
        hist_d[n] = model[a];
        if (e && w) begin
            model[a] = d;
            known[a] = 1'b1;
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom, $urandom, $urandom});
    endfunction

    initial begin
        for (int i = 0; i < NWORD; i++) begin
            known[i] = 1'b0;
            model[i] = '0;
        end
        for (int k = 0; k < 3; k++) last_ok[k] = 1'b0;

        // R7: quiet during and straight after reset.
        repeat (2) step(1'b0, 1'b0, '0, '0);
        chk_on = 1'b1;
        repeat (3) step(1'b0, 1'b0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) step(1'b0, 1'b0, '0, '0);

        // R1: fill every word of all 16 tiles, then sweep tiles at one index.
        ph = "R1";
        for (int a = 0; a < NWORD; a++) step(1'b1, 1'b1, AW'(a), rnd_word());
        for (int t = 0; t < 16; t++) step(1'b1, 1'b0, AW'((t << 8) | 7), '0);
        repeat (12) step(1'b0, 1'b0, '0, '0);

        // R2: disabled write and enabled read with wr_en low both leave the word.
        ph = "R2";
        step(1'b0, 1'b1, 12'h5A3, rnd_word());
        step(1'b1, 1'b0, 12'h5A3, rnd_word());
        step(1'b1, 1'b0, 12'h5A3, '0);
        repeat (12) step(1'b0, 1'b0, '0, '0);

        // R3: read-first on a write, then the new word.
        ph = "R3";
        step(1'b1, 1'b1, 12'hC41, rnd_word());
        step(1'b1, 1'b0, 12'hC41, '0);
        step(1'b1, 1'b1, 12'h0FF, rnd_word());
        step(1'b1, 1'b1, 12'h0FF, rnd_word());
        step(1'b1, 1'b0, 12'h0FF, '0);
        repeat (12) step(1'b0, 1'b0, '0, '0);

        // R5: long unbroken burst crossing every tile.
        ph = "R5";
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, AW'(i * 67), '0);
        repeat (12) step(1'b0, 1'b0, '0, '0);

        // R4: random mix of reads, writes and idle cycles.
        ph = "R4";
        for (int i = 0; i < 1500; i++) begin
            bit e = ($urandom % 4) != 0;
            bit w = ($urandom % 3) == 0;
            step(e, w, AW'($urandom), rnd_word());
        end
        repeat (14) step(1'b0, 1'b0, '0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule